// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block runs the low-power state of a small 8-bit processor core. One clock of the block is one instruction cycle. When the instruction decoder flags a sleep instruction, the block decides whether to honour it. It holds the core halted while asleep and watches three wake sources: the external reset pin, the watchdog timeout and the masked interrupt flags. When a source fires, it clears the watchdog and holds the core until the oscillator has settled. It then lets the already-fetched next instruction run. If the wake came from an interrupt with global interrupts on, it requests the jump to the interrupt vector after one dummy cycle.

Two status bits record what happened. `pd_bit` goes low when a sleep is entered. `to_bit` goes low when the watchdog woke the core. A reset request is raised whenever the reset pin is low. After a crystal-type wake the halt lasts `OST_CYCLES` cycles. After an RC-mode wake execution resumes on the next cycle.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: During and after synchronous reset `rst`: halt=0, to_bit=1, pd_bit=1, wdt_clr=0, rst_req=0, vector_req=0, ost_count=0.
- R2: In normal running with mclr_n=1, a sleep_req sampled while no interrupt has both its flag and enable bit set raises halt on the next cycle, clears pd_bit and sets to_bit.
- R3: A sleep_req sampled while any bit of int_flags & int_enables is 1 is a no-op: halt stays 0 and pd_bit is unchanged.
- R4: While asleep, an interrupt wakes the core exactly when some flag bit and its matching enable bit are both 1, whatever the value of gie. Flags whose enable bit is 0 do not wake it.
- R5: While asleep, wdt_timeout wakes the core and clears to_bit only when wdt_en=1. With wdt_en=0 it has no effect.
- R6: mclr_n=0 in any state gives rst_req=1 on the next cycle. It ends sleep or start-up with halt=0 and leaves to_bit and pd_bit unchanged. A sleep_req is ignored while mclr_n=0.
- R7: Wake cause priority is reset pin, then watchdog, then interrupt. A simultaneous watchdog and interrupt wake clears to_bit and gives no vector request.
- R8: Every wake out of sleep, from any source, produces a wdt_clr pulse of exactly one cycle, in the cycle after the wake is sampled.
- R9: With osc_mode=0 (crystal), halt stays 1 for OST_CYCLES cycles after the wake edge, while ost_count counts 0 to OST_CYCLES-1. It then falls to 0.
- R10: With osc_mode=1 (RC), halt falls to 0 in the cycle right after the wake is sampled.
- R11: After halt falls following a watchdog or interrupt wake, there is one cycle with vector_req=0, in which the prefetched instruction runs. If the wake was an interrupt and gie=1, vector_req is 1 for exactly the following cycle. Otherwise it stays 0.
- R12: In normal running, wdt_timeout and int_flags by themselves change neither halt, to_bit nor pd_bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_req | input | 1 | Decoded sleep instruction strobe |
| mclr_n | input | 1 | External reset pin, active low |
| wdt_timeout | input | 1 | Watchdog timeout event |
| wdt_en | input | 1 | Watchdog enabled |
| int_flags | input | NSRC | Interrupt flag bits |
| int_enables | input | NSRC | Individual interrupt enable bits |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 1 | 0 = crystal type (start-up delay), 1 = RC (no delay) |
| halt | output | 1 | Core clock gate / halt |
| ost_count | output | CW | Oscillator start-up counter value |
| wdt_clr | output | 1 | Watchdog clear pulse |
| rst_req | output | 1 | Device reset request |
| vector_req | output | 1 | Branch to interrupt vector request |
| to_bit | output | 1 | Timeout status bit |
| pd_bit | output | 1 | Power-down status bit |

## Verification
A stuck or wrongly entered sequencer state shows up at once on `halt`. The core either fails to stop one cycle after a sleep request or stays stopped one cycle after a wake. A wrong wake cause shows on `to_bit` in the cycle after the wake. It also shows two cycles after the halt ends, as a missing or spurious `vector_req`. A start-up counter that is off by one moves the falling edge of `halt` by exactly one cycle. So the crystal-mode wake is timed cycle-exact against `OST_CYCLES`.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_OST    = 3'd2,
    ST_RESUME = 3'd3,
    ST_DUMMY  = 3'd4
  } swk_state_e;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_PIN  = 2'd1,
    WK_WDT  = 2'd2,
    WK_IRQ  = 2'd3
  } swk_cause_e;
endpackage

// File: rtl/swk_wake_arbiter.sv
module swk_wake_arbiter
  import swk_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            mclr_n,
  input  logic            wdt_timeout,
  input  logic            wdt_en,
  input  logic [NSRC-1:0] int_flags,
  input  logic [NSRC-1:0] int_enables,
  output logic            pending,
  output swk_cause_e      cause
);
  logic [NSRC-1:0] armed;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_mask
      assign armed[g] = int_flags[g] & int_enables[g];
    end
  endgenerate

  assign pending = |armed;

  always_comb begin
    if (!mclr_n)                  cause = WK_PIN;
    else if (wdt_timeout && wdt_en) cause = WK_WDT;
    else if (pending)             cause = WK_IRQ;
    else                          cause = WK_NONE;
  end
endmodule

// File: rtl/swk_ost_timer.sv
module swk_ost_timer #(
  parameter int OST_CYCLES = 1024,
  localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          enter,
  output logic [CW-1:0] count,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst || !active || enter) count <= '0;
    else                         count <= count + 1'b1;
  end

  assign done = (count == LAST);
endmodule

// File: rtl/swk_status.sv
module swk_status (
  input  logic clk,
  input  logic rst,
  input  logic enter_sleep,
  input  logic wdt_wake,
  output logic to_bit,
  output logic pd_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      to_bit <= 1'b1;
      pd_bit <= 1'b1;
    end else if (enter_sleep) begin
      to_bit <= 1'b1;
      pd_bit <= 1'b0;
    end else if (wdt_wake) begin
      to_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swk_pkg::*;
#(
  parameter int NSRC       = 8,
  parameter int OST_CYCLES = 1024,
  localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_req,
  input  logic            mclr_n,
  input  logic            wdt_timeout,
  input  logic            wdt_en,
  input  logic [NSRC-1:0] int_flags,
  input  logic [NSRC-1:0] int_enables,
  input  logic            gie,
  input  logic            osc_mode,
  output logic            halt,
  output logic [CW-1:0]   ost_count,
  output logic            wdt_clr,
  output logic            rst_req,
  output logic            vector_req,
  output logic            to_bit,
  output logic            pd_bit
);
  swk_state_e state_q, state_d;
  swk_cause_e cause_q, cause_d, cause_now;
  logic       pending, ost_done;
  logic       enter_sleep, wdt_wake, wake;

  swk_wake_arbiter #(.NSRC(NSRC)) u_arb (
    .mclr_n      (mclr_n),
    .wdt_timeout (wdt_timeout),
    .wdt_en      (wdt_en),
    .int_flags   (int_flags),
    .int_enables (int_enables),
    .pending     (pending),
    .cause       (cause_now)
  );

  swk_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk    (clk),
    .rst    (rst),
    .active (state_d == ST_OST),
    .enter  (state_q != ST_OST),
    .count  (ost_count),
    .done   (ost_done)
  );

  swk_status u_stat (
    .clk         (clk),
    .rst         (rst),
    .enter_sleep (enter_sleep),
    .wdt_wake    (wdt_wake),
    .to_bit      (to_bit),
    .pd_bit      (pd_bit)
  );

  always_comb begin
    state_d     = state_q;
    cause_d     = cause_q;
    enter_sleep = 1'b0;
    wdt_wake    = 1'b0;
    wake        = 1'b0;
    if (!mclr_n) begin
      state_d = ST_RUN;
      cause_d = WK_PIN;
      wake    = (state_q == ST_SLEEP);
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (sleep_req && !pending) begin
            state_d     = ST_SLEEP;
            enter_sleep = 1'b1;
          end
        end
        ST_SLEEP: begin
          if (cause_now != WK_NONE) begin
            wake     = 1'b1;
            cause_d  = cause_now;
            wdt_wake = (cause_now == WK_WDT);
            state_d  = osc_mode ? ST_RESUME : ST_OST;
          end
        end
        ST_OST: begin
          if (ost_done) state_d = ST_RESUME;
        end
        ST_RESUME: begin
          state_d = (cause_q == WK_IRQ && gie) ? ST_DUMMY : ST_RUN;
        end
        ST_DUMMY: state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      cause_q    <= WK_NONE;
      halt       <= 1'b0;
      wdt_clr    <= 1'b0;
      rst_req    <= 1'b0;
      vector_req <= 1'b0;
    end else begin
      state_q    <= state_d;
      cause_q    <= cause_d;
      halt       <= (state_d == ST_SLEEP) || (state_d == ST_OST);
      wdt_clr    <= wake;
      rst_req    <= !mclr_n;
      vector_req <= (state_d == ST_DUMMY);
    end
  end
endmodule

// File: rtl/swk_checker.sv
module swk_checker
  import swk_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int CW   = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            sleep_req,
  input logic            mclr_n,
  input logic            wdt_timeout,
  input logic            wdt_en,
  input logic [NSRC-1:0] int_flags,
  input logic [NSRC-1:0] int_enables,
  input logic            osc_mode,
  input logic            halt,
  input logic [CW-1:0]   ost_count,
  input logic            wdt_clr,
  input logic            rst_req,
  input logic            vector_req,
  input logic            to_bit,
  input logic            pd_bit,
  input swk_state_e      state
);
  logic pend;
  assign pend = |(int_flags & int_enables);

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && mclr_n && sleep_req && !pend) |=> (halt && !pd_bit && to_bit));

  assert_sleep_noop_R3: assert property (@(posedge clk) disable iff (rst)
    (!halt && pend) |=> (!halt && $stable(pd_bit)));

  assert_irq_wake_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && mclr_n && !(wdt_timeout && wdt_en) && pend) |=> (state != ST_SLEEP));

  assert_no_false_wake_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && mclr_n && !(wdt_timeout && wdt_en) && !pend) |=> (state == ST_SLEEP));

  assert_wdt_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && mclr_n && wdt_timeout && wdt_en) |=> (!to_bit && wdt_clr));

  assert_pin_reset_R6: assert property (@(posedge clk) disable iff (rst)
    (!mclr_n) |=> (rst_req && !halt && $stable(to_bit) && $stable(pd_bit)));

  assert_wdt_clr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |=> !wdt_clr);

  assert_ost_count_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OST && $past(state) == ST_OST) |-> (ost_count == CW'($past(ost_count) + 1'b1)));

  assert_rc_resume_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && mclr_n && osc_mode && (pend || (wdt_timeout && wdt_en))) |=> !halt);

  assert_vector_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    vector_req |=> !vector_req);

  assert_vector_after_run_R11: assert property (@(posedge clk) disable iff (rst)
    vector_req |-> (!halt && !$past(halt) && !$past(vector_req)));

  assert_quiet_run_R12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && mclr_n && !sleep_req) |=> (!halt && $stable(to_bit) && $stable(pd_bit)));
endmodule

bind sleep_wake_ctrl swk_checker #(.NSRC(NSRC), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sleep_req   (sleep_req),
  .mclr_n      (mclr_n),
  .wdt_timeout (wdt_timeout),
  .wdt_en      (wdt_en),
  .int_flags   (int_flags),
  .int_enables (int_enables),
  .osc_mode    (osc_mode),
  .halt        (halt),
  .ost_count   (ost_count),
  .wdt_clr     (wdt_clr),
  .rst_req     (rst_req),
  .vector_req  (vector_req),
  .to_bit      (to_bit),
  .pd_bit      (pd_bit),
  .state       (state_q)
);

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
  localparam int NSRC = 8;
  localparam int OST  = 1024;
  localparam int CW   = $clog2(OST);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, mclr_n = 1'b1, wdt_timeout = 1'b0, wdt_en = 1'b0;
  logic [NSRC-1:0] int_flags = '0, int_enables = '0;
  logic gie = 1'b0, osc_mode = 1'b1;
  logic halt, wdt_clr, rst_req, vector_req, to_bit, pd_bit;
  logic [CW-1:0] ost_count;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NSRC(NSRC), .OST_CYCLES(OST)) uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .mclr_n(mclr_n),
    .wdt_timeout(wdt_timeout), .wdt_en(wdt_en), .int_flags(int_flags),
    .int_enables(int_enables), .gie(gie), .osc_mode(osc_mode),
    .halt(halt), .ost_count(ost_count), .wdt_clr(wdt_clr), .rst_req(rst_req),
    .vector_req(vector_req), .to_bit(to_bit), .pd_bit(pd_bit)
  );

  // [17:10] flags, [9:2] enables, [1] gie, [0] sleep expected
  localparam logic [17:0] VECS [0:7] = '{
    {8'h00, 8'h00, 1'b0, 1'b1},
    {8'hFF, 8'h00, 1'b0, 1'b1},
    {8'h00, 8'hFF, 1'b1, 1'b1},
    {8'h01, 8'h01, 1'b0, 1'b0},
    {8'h80, 8'h80, 1'b1, 1'b0},
    {8'h0F, 8'hF0, 1'b1, 1'b1},
    {8'h55, 8'hAA, 1'b0, 1'b1},
    {8'h10, 8'h30, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sleep_req = 0; mclr_n = 1; wdt_timeout = 0; wdt_en = 0;
    int_flags = '0; int_enables = '0; gie = 0; osc_mode = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 halt", halt, 0);
    chk("R1 to_bit", to_bit, 1);
    chk("R1 pd_bit", pd_bit, 1);
    chk("R1 outputs", {wdt_clr, rst_req, vector_req}, 0);
    chk("R1 ost_count", ost_count, 0);

    // R2/R3 table of sleep decisions
    for (int i = 0; i < 8; i++) begin
      do_reset();
      int_flags = VECS[i][17:10]; int_enables = VECS[i][9:2]; gie = VECS[i][1];
      go_sleep();
      chk(VECS[i][0] ? "R2 halt" : "R3 halt", halt, VECS[i][0]);
      chk(VECS[i][0] ? "R2 pd_bit" : "R3 pd_bit", pd_bit, !VECS[i][0]);
    end

    // R12 run-time events ignored
    do_reset();
    wdt_en = 1; wdt_timeout = 1; int_flags = 8'hFF;
    @(negedge clk);
    wdt_timeout = 0; int_flags = '0;
    @(negedge clk);
    chk("R12 halt", halt, 0);
    chk("R12 status", {to_bit, pd_bit}, 3);

    // R4 flags without enable do not wake; then enabled flag wakes with gie=0, RC (R10, R11)
    do_reset();
    int_enables = 8'h04;
    go_sleep();
    int_flags = 8'hFB;
    repeat (3) @(negedge clk);
    chk("R4 no wake on masked flags", halt, 1);
    int_flags = 8'h04;
    @(negedge clk);
    int_flags = '0;
    chk("R10 halt falls next cycle", halt, 0);
    chk("R8 wdt_clr pulse", wdt_clr, 1);
    chk("R4 to_bit kept", to_bit, 1);
    @(negedge clk);
    chk("R8 wdt_clr one cycle", wdt_clr, 0);
    chk("R11 no vector with gie=0", vector_req, 0);
    @(negedge clk);
    chk("R11 no vector later", vector_req, 0);

    // R11 interrupt wake with gie=1: one run cycle, then one vector cycle
    do_reset();
    int_enables = 8'h01; gie = 1;
    go_sleep();
    int_flags = 8'h01;
    @(negedge clk);
    int_flags = '0;
    chk("R11 prefetched cycle halt", halt, 0);
    chk("R11 prefetched cycle vector", vector_req, 0);
    @(negedge clk);
    chk("R11 vector pulse", vector_req, 1);
    @(negedge clk);
    chk("R11 vector ends", vector_req, 0);

    // R5 watchdog ignored when disabled, wakes when enabled
    do_reset();
    go_sleep();
    wdt_timeout = 1;
    @(negedge clk);
    chk("R5 disabled wdt no wake", halt, 1);
    wdt_en = 1;
    @(negedge clk);
    wdt_timeout = 0;
    chk("R5 wake", halt, 0);
    chk("R5 to_bit cleared", to_bit, 0);

    // R7 watchdog beats interrupt, gie=1: no vector
    do_reset();
    wdt_en = 1; gie = 1; int_enables = 8'h02;
    go_sleep();
    wdt_timeout = 1; int_flags = 8'h02;
    @(negedge clk);
    wdt_timeout = 0; int_flags = '0;
    chk("R7 to_bit", to_bit, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 no vector", vector_req, 0);

    // R6 reset pin wakes, wins over others, status kept, sleep ignored
    do_reset();
    wdt_en = 1; int_enables = 8'h08;
    go_sleep();
    mclr_n = 0; wdt_timeout = 1; int_flags = 8'h08;
    @(negedge clk);
    wdt_timeout = 0; int_flags = '0;
    chk("R6 rst_req", rst_req, 1);
    chk("R6 halt", halt, 0);
    chk("R6 status", {to_bit, pd_bit}, 2);
    chk("R8 wdt_clr on pin wake", wdt_clr, 1);
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
    chk("R6 sleep ignored", halt, 0);
    mclr_n = 1;
    @(negedge clk);
    chk("R6 rst_req drops", rst_req, 0);

    // R9 crystal start-up delay
    do_reset();
    osc_mode = 0; wdt_en = 1;
    go_sleep();
    wdt_timeout = 1;
    @(negedge clk);
    wdt_timeout = 0;
    chk("R9 halt held", halt, 1);
    chk("R9 count start", ost_count, 0);
    repeat (OST - 1) @(negedge clk);
    chk("R9 halt at last", halt, 1);
    chk("R9 count last", ost_count, OST - 1);
    @(negedge clk);
    chk("R9 halt released", halt, 0);
    chk("R9 count cleared", ost_count, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule